// File: doc/BRIEF.md
# Banked Data Memory with Fixed Access Window

This block is the byte-wide data store behind a small processor's file-register operand path. Physical storage spans 16 banks of 256 bytes, addressed by a 12-bit physical address. Each access carries an 8-bit file address and a one-bit mode select. In banked mode, a 4-bit bank register provides the upper four address bits. In window mode, the bank register is bypassed and the file address lands in a fixed window. The lower part of that window covers the start of bank 0, and the upper part covers the top of bank 15, where the special-register area lives.

Writes are synchronous. Reads are combinational from the resolved address. A byte load into the bank register keeps its low four bits and takes effect on the next cycle. General-purpose storage is implemented from address 000h up to a parameterised top address. The special-register area is implemented from F53h up to FFFh as plain storage, without side effects. Any other physical address reads as 00h and ignores writes. The resolved physical address is also driven out for observation.

Top module: `dmem_access`

## Requirements
- R1: With the mode bit `banked_i` = 1, the physical address is {bank register[3:0], file address[7:0]}.
- R2: With `banked_i` = 0, the bank register value has no effect on the physical address or on the read data.
- R3: With `banked_i` = 0 and file address 00h–5Fh, the physical address is 000h + file address, which is the first 96 bytes of bank 0.
- R4: With `banked_i` = 0 and file address 60h–FFh, the physical address is F00h + file address, which is F60h–FFFh, the last 160 bytes of bank 15.
- R5: Physical bytes F53h–F5Fh can be written and read through banked access with bank 15. The same file addresses in window mode reach 053h–05Fh instead.
- R6: Physical addresses above `GPR_TOP` and below F53h read as 00h, and writes to them are dropped.
- R7: A write stores `wr_data_i` at the resolved address on the clock edge. The combinational read shows the new byte from the next cycle onward and shows the old byte in the cycle of the write.
- R8: Asserting `bank_ld_i` loads `bank_data_i[3:0]` into the bank register. Bits above bit 3 are discarded. The new value governs banked addresses from the following cycle. A write in the same cycle still uses the old bank.
- R9: After reset the bank register is 0 and every implemented byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| file_addr_i | input | 8 | File address from the instruction |
| banked_i | input | 1 | 1: use bank register, 0: use fixed access window |
| wr_en_i | input | 1 | Write strobe for the resolved address |
| wr_data_i | input | 8 | Write data |
| bank_ld_i | input | 1 | Load the bank register |
| bank_data_i | input | 8 | Bank load value (low 4 bits kept) |
| rd_data_o | output | 8 | Combinational read data |
| phys_addr_o | output | 12 | Resolved physical address |

## Verification
The bench builds the block with `GPR_TOP` = 17Fh. This places the last implemented general-purpose byte in the middle of bank 1, so both sides of the implemented/unimplemented edge can be reached with a single bank value. It also leaves a wide hole of unimplemented addresses up to F52h, which exercises the zero-read and dropped-write behaviour. The special-register base stays at F53h, so the thirteen bytes that only banked access can reach sit right below the window's upper half. Directed sequences hit each of these edges. A long pseudo-random run then mixes modes, writes and bank loads, and every cycle is compared against the bench's own model.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  parameter int unsigned FILE_W = 8;
  parameter int unsigned BANK_W = 4;
  parameter int unsigned DATA_W = 8;
  localparam int unsigned PHYS_W = BANK_W + FILE_W;
  localparam int unsigned N_REGION = 2;

  typedef enum logic {
    MODE_WINDOW = 1'b0,
    MODE_BANKED = 1'b1
  } acc_mode_e;

  typedef logic [PHYS_W-1:0] phys_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/dmem_bank_reg.sv
module dmem_bank_reg import dmem_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o
);
  // upper bits of the load byte are discarded by design
  logic unused_hi;
  assign unused_hi = ^data_i[DATA_W-1:BANK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bank_o <= '0;
    else if (ld_i) bank_o <= data_i[BANK_W-1:0];
  end
endmodule

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve import dmem_pkg::*; #(
  parameter logic [FILE_W-1:0] WIN_SPLIT = 8'h60
) (
  input  acc_mode_e         mode_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [FILE_W-1:0] file_i,
  output logic [PHYS_W-1:0] phys_o
);
  logic [BANK_W-1:0] win_bank;

  // window: low part from first bank, high part from last bank
  assign win_bank = (file_i < WIN_SPLIT) ? '0 : '1;

  always_comb begin
    unique case (mode_i)
      MODE_BANKED: phys_o = {bank_i, file_i};
      default:     phys_o = {win_bank, file_i};
    endcase
  end
endmodule

// File: rtl/dmem_byte_store.sv
module dmem_byte_store import dmem_pkg::*; #(
  parameter int unsigned BASE  = 0,
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PHYS_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LIMIT = BASE + DEPTH;
  localparam logic [PHYS_W-1:0] BASE_A = PHYS_W'(BASE);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              hit;
  logic [PHYS_W-1:0] off_full;
  logic [IW-1:0]     idx;

  assign hit      = (32'(addr_i) >= BASE) && (32'(addr_i) < LIMIT);
  assign off_full = addr_i - BASE_A;
  assign idx      = off_full[IW-1:0];
  assign rdata_o  = hit ? mem[idx] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i && hit) begin
      mem[idx] <= wdata_i;
    end
  end
endmodule

// File: rtl/dmem_access.sv
module dmem_access import dmem_pkg::*; #(
  parameter logic [PHYS_W-1:0] GPR_TOP   = 12'h2FF,
  parameter logic [PHYS_W-1:0] SFR_BASE  = 12'hF53,
  parameter logic [FILE_W-1:0] WIN_SPLIT = 8'h60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FILE_W-1:0] file_addr_i,
  input  logic              banked_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bank_ld_i,
  input  logic [DATA_W-1:0] bank_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PHYS_W-1:0] phys_addr_o
);
  localparam int unsigned SPACE = 2 ** PHYS_W;
  localparam int unsigned REG_BASE  [N_REGION] = '{0, int'(SFR_BASE)};
  localparam int unsigned REG_DEPTH [N_REGION] = '{int'(GPR_TOP) + 1,
                                                  SPACE - int'(SFR_BASE)};

  logic [BANK_W-1:0] bank_q;
  acc_mode_e         mode;
  logic [DATA_W-1:0] rd_arr [N_REGION];

  assign mode = acc_mode_e'(banked_i);

  dmem_bank_reg u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (bank_ld_i),
    .data_i (bank_data_i),
    .bank_o (bank_q)
  );

  dmem_addr_resolve #(.WIN_SPLIT(WIN_SPLIT)) u_resolve (
    .mode_i (mode),
    .bank_i (bank_q),
    .file_i (file_addr_i),
    .phys_o (phys_addr_o)
  );

  for (genvar g = 0; g < N_REGION; g++) begin : g_region
    dmem_byte_store #(
      .BASE  (REG_BASE[g]),
      .DEPTH (REG_DEPTH[g])
    ) u_store (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (phys_addr_o),
      .we_i    (wr_en_i),
      .wdata_i (wr_data_i),
      .rdata_o (rd_arr[g])
    );
  end

  // regions are disjoint, non-hit stores drive zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_REGION; i++) rd_data_o = rd_data_o | rd_arr[i];
  end
endmodule

// File: rtl/dmem_access_chk.sv
module dmem_access_chk import dmem_pkg::*; #(
  parameter logic [PHYS_W-1:0] GPR_TOP   = 12'h2FF,
  parameter logic [PHYS_W-1:0] SFR_BASE  = 12'hF53,
  parameter logic [FILE_W-1:0] WIN_SPLIT = 8'h60
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FILE_W-1:0] file_addr_i,
  input logic              banked_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              bank_ld_i,
  input logic [DATA_W-1:0] bank_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [PHYS_W-1:0] phys_addr_o
);
  logic past_ok;
  logic in_hole;
  logic impl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign in_hole = (phys_addr_o > GPR_TOP) && (phys_addr_o < SFR_BASE);
  assign impl    = !in_hole;

  // R1
  banked_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    banked_i |-> phys_addr_o[FILE_W-1:0] == file_addr_i);

  // R3
  win_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!banked_i && file_addr_i < WIN_SPLIT) |-> phys_addr_o == PHYS_W'(file_addr_i));

  // R4
  win_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!banked_i && file_addr_i >= WIN_SPLIT) |-> phys_addr_o[PHYS_W-1:FILE_W] == '1);

  // R6
  hole_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_hole |-> rd_data_o == '0);

  // R7
  write_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && impl) |=> (phys_addr_o != $past(phys_addr_o) || rd_data_o == $past(wr_data_i)));

  // R8
  bank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && banked_i && $past(bank_ld_i))
      |-> phys_addr_o[PHYS_W-1:FILE_W] == $past(bank_data_i[BANK_W-1:0]));
endmodule

bind dmem_access dmem_access_chk #(
  .GPR_TOP   (GPR_TOP),
  .SFR_BASE  (SFR_BASE),
  .WIN_SPLIT (WIN_SPLIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .file_addr_i (file_addr_i),
  .banked_i    (banked_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .bank_ld_i   (bank_ld_i),
  .bank_data_i (bank_data_i),
  .rd_data_o   (rd_data_o),
  .phys_addr_o (phys_addr_o)
);

// File: tb/dmem_access_test.sv
`timescale 1ns/1ps
module dmem_access_test;
  localparam int GPR_TOP_T = 'h17F;
  localparam int SFR_LO    = 'hF53;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] file_addr_i = '0;
  logic       banked_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       bank_ld_i = 1'b0;
  logic [7:0] bank_data_i = '0;
  logic [7:0] rd_data_o;
  logic [11:0] phys_addr_o;

  dmem_access #(.GPR_TOP(12'h17F)) uut (
    .clk_i, .rst_ni, .file_addr_i, .banked_i, .wr_en_i, .wr_data_i,
    .bank_ld_i, .bank_data_i, .rd_data_o, .phys_addr_o
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mdl_mem [int];
  int mdl_bank = 0;

  function automatic int map(int fa, bit bk, int bank);
    if (bk) return bank * 256 + fa;
    if (fa < 'h60) return fa;
    return 'hF00 + fa;
  endfunction

  function automatic bit impl(int p);
    return (p <= GPR_TOP_T) || (p >= SFR_LO);
  endfunction

  function automatic int mdl_rd(int p);
    if (impl(p) && mdl_mem.exists(p)) return mdl_mem[p];
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // one cycle: drive at negedge, compare, then advance model at posedge
  task automatic step(int fa, bit bk, bit we, int wd, bit ld, int ldd);
    int p;
    @(negedge clk_i);
    file_addr_i = 8'(fa); banked_i = bk; wr_en_i = we;
    wr_data_i = 8'(wd); bank_ld_i = ld; bank_data_i = 8'(ldd);
    #1;
    p = map(fa, bk, mdl_bank);
    check(bk ? "R1" : (fa < 'h60 ? "R3" : "R4"), int'(phys_addr_o), p);
    check(impl(p) ? "R7" : "R6", int'(rd_data_o), mdl_rd(p));
    @(posedge clk_i);
    if (we && impl(p)) mdl_mem[p] = wd & 'hFF;
    if (ld) mdl_bank = ldd & 'hF;
  endtask

  task automatic peek(int fa, bit bk);
    @(negedge clk_i);
    file_addr_i = 8'(fa); banked_i = bk; wr_en_i = 0; bank_ld_i = 0;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R9 reset state
    peek('h42, 1);
    check("R9", int'(phys_addr_o), 'h042);
    check("R9", int'(rd_data_o), 0);
    peek('h60, 0);
    check("R9", int'(rd_data_o), 0);

    // R8 load with high bits, same-cycle write uses old bank
    step('h10, 1, 1, 'hA5, 1, 'hF1);
    peek('h10, 1);
    check("R8", int'(phys_addr_o), 'h110);
    check("R8", int'(rd_data_o), 0);
    peek('h10, 0);
    check("R8", int'(rd_data_o), 'hA5);

    // R7 top implemented byte, R6 first hole byte
    step('h7F, 1, 1, 'h5A, 0, 0);
    peek('h7F, 1);
    check("R7", int'(rd_data_o), 'h5A);
    step('h80, 1, 1, 'h77, 0, 0);
    peek('h80, 1);
    check("R6", int'(rd_data_o), 0);
    step('h00, 1, 1, 'h33, 1, 'h0E);
    peek('hFF, 1);
    check("R6", int'(rd_data_o), 0);

    // R5 banked-only special bytes
    step('h00, 1, 0, 0, 1, 'h0F);
    step('h55, 1, 1, 'hC3, 0, 0);
    peek('h55, 1);
    check("R5", int'(phys_addr_o), 'hF55);
    check("R5", int'(rd_data_o), 'hC3);
    peek('h55, 0);
    check("R5", int'(phys_addr_o), 'h055);
    check("R5", int'(rd_data_o), 0);

    // R3/R4 window edges, window write seen through bank 15
    peek('h5F, 0); check("R3", int'(phys_addr_o), 'h05F);
    peek('h60, 0); check("R4", int'(phys_addr_o), 'hF60);
    peek('hFF, 0); check("R4", int'(phys_addr_o), 'hFFF);
    step('h60, 0, 1, 'h9C, 0, 0);
    peek('h60, 1);
    check("R4", int'(rd_data_o), 'h9C);

    // R2 bank value ignored in window mode
    for (int b = 0; b < 16; b += 5) begin
      step('h00, 1, 0, 0, 1, b);
      peek('h60, 0);
      check("R2", int'(phys_addr_o), 'hF60);
      check("R2", int'(rd_data_o), 'h9C);
    end

    // mixed traffic against model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom);
      step(r & 'hFF, r[8], r[9], (r >> 10) & 'hFF, (r[20:18] == 0),
           (r[21] ? 'h0F : 'h00) ^ ((r >> 22) & 'hFF));
    end
    finish_run();
  end
endmodule